// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls a port of general-purpose pins. A simple register bus (address, write enable, write data, combinational read data) exposes three registers. The direction register picks output or input for each pin. The output latch gives the driven level for output pins and the pull-up request for input pins. The pin-input location returns the pad level after synchronization. Writing ones to the pin-input location inverts the matching output latch bits, so one write can flip any set of pins.

For each pin the block gives an output enable, an output value and a pull-up enable to the pad cell, and it takes the raw pad level back. A global pull-up-off input turns off every pull-up. The pad level goes through a latch that is open while the clock is low and then through a rising-edge flop. This guards against metastability at the cost of a short delay.

Top module: `gpio_port`

## Requirements
- R1: In reset the direction and output latch registers are zero, so every pin has output enable 0 and pull-up 0, and reading address 1 or 2 returns 0.
- R2: A pin whose direction bit is 1 has output enable 1 and drives its output latch bit, where 1 means high and 0 means low.
- R3: Writing to address 0 inverts each output latch bit whose write-data bit is 1, whatever the direction bits hold. Bits written as 0 are left unchanged.
- R4: A pin with direction bit 0 and latch bit 1 has its pull-up enabled when pull-up-off is 0.
- R5: A pin with direction bit 0 and latch bit 0 has no pull-up. When pull-up-off is 1, no pin has a pull-up.
- R6: A pin never has output enable and pull-up set together.
- R7: Reading address 1 returns the direction register and reading address 2 returns the output latch. Reading address 0 returns the synchronized pad level for every pin, whatever its direction, so an output pin reads back its own level.
- R8: A pad change made while the clock is low shows at address 0 after the next rising edge. A change made while the clock is high shows after the rising edge that follows the next falling edge. Before that edge the read returns the old value.
- R9: Address map: 0 is pin input (write toggles), 1 is direction, 2 is output latch. Writes to address 3 change nothing, and reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pullup_off | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The pin-control function is tried with a table of direction, latch and pull-up-off combinations. These include all-input, all-output and mixed byte patterns, with pull-up-off both clear and set. This shows whether drive, pull-up and tri-state are picked per bit from both control bits and whether the global disable overrides them. Directed tests toggle with a mixed mask on mixed directions, then write an all-zero mask. This shows whether the toggle is a per-bit XOR and not a plain store. Pad changes are placed in the low phase and in the high phase of the clock. This shows whether the latch-front synchronizer gives the stated delay, as against a two-flop chain or no synchronizer at all.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int REG_AW = 2;
   typedef enum logic [REG_AW-1:0] {
      REG_PIN  = 2'd0,
      REG_DIR  = 2'd1,
      REG_LAT  = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] addr,
   input  logic [W-1:0]      wdata,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      lat_q
);
   reg_sel_e sel;
   assign sel = reg_sel_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         lat_q <= '0;
      end else if (we) begin
         case (sel)
            REG_PIN: lat_q <= lat_q ^ wdata;
            REG_DIR: dir_q <= wdata;
            REG_LAT: lat_q <= wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W           = 8,
   parameter bit LATCH_FRONT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pad_i,
   output logic [W-1:0] sync_o
);
   logic [W-1:0] front;

   generate
      if (LATCH_FRONT) begin : g_latch
         always_latch begin
            if (!clk) front = pad_i;
         end
      end else begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) front <= '0;
            else        front <= pad_i;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_o <= '0;
      else        sync_o <= front;
   end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int W = 8
) (
   input  logic [W-1:0] dir,
   input  logic [W-1:0] lat,
   input  logic         pud,
   output logic [W-1:0] oe,
   output logic [W-1:0] out,
   output logic [W-1:0] pu
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         always_comb begin
            oe[i]  = dir[i];
            out[i] = lat[i];
            pu[i]  = !dir[i] && lat[i] && !pud;
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int W           = 8,
   parameter bit LATCH_FRONT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [W-1:0]      bus_wdata,
   output logic [W-1:0]      bus_rdata,
   input  logic              pullup_off,
   input  logic [W-1:0]      pad_in,
   output logic [W-1:0]      pad_oe,
   output logic [W-1:0]      pad_out,
   output logic [W-1:0]      pad_pu
);
   generate
      if (W < 1 || W > 32) begin : g_bad_width
         $error("gpio_port: W must be 1..32");
      end
   endgenerate

   logic [W-1:0] dir_q, lat_q, pin_sync;

   gpio_regs #(.W(W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .dir_q(dir_q), .lat_q(lat_q)
   );

   gpio_in_sync #(.W(W), .LATCH_FRONT(LATCH_FRONT)) u_sync (
      .clk(clk), .rst_n(rst_n), .pad_i(pad_in), .sync_o(pin_sync)
   );

   gpio_pin_mux #(.W(W)) u_mux (
      .dir(dir_q), .lat(lat_q), .pud(pullup_off),
      .oe(pad_oe), .out(pad_out), .pu(pad_pu)
   );

   always_comb begin
      case (reg_sel_e'(bus_addr))
         REG_PIN: bus_rdata = pin_sync;
         REG_DIR: bus_rdata = dir_q;
         REG_LAT: bus_rdata = lat_q;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   bus_addr,
   input logic         bus_we,
   input logic [W-1:0] bus_wdata,
   input logic [W-1:0] bus_rdata,
   input logic         pullup_off,
   input logic [W-1:0] pad_oe,
   input logic [W-1:0] pad_out,
   input logic [W-1:0] pad_pu
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (pad_oe == '0 && pad_pu == '0 && pad_out == '0));

   assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 2'd1) |=> pad_oe == $past(bus_wdata));

   assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 2'd0) |=> pad_out == ($past(pad_out) ^ $past(bus_wdata)));

   assert_pullup_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pullup_off |-> pad_pu == (~pad_oe & pad_out));

   assert_pud_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pullup_off |-> pad_pu == '0);

   assert_no_pu_on_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_pu) == '0);

   assert_lat_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == 2'd2 |-> bus_rdata == pad_out);

   assert_hole_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 2'd3) |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pullup_off(pullup_off),
   .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       pullup_off = 1'b0;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_oe, pad_out, pad_pu;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pullup_off(pullup_off),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );

   // {dir, latch, pud, exp_oe, exp_out, exp_pu}
   localparam int NV = 7;
   localparam logic [40:0] VEC [NV] = '{
      {8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00},
      {8'h00, 8'hFF, 1'b0, 8'h00, 8'hFF, 8'hFF},
      {8'h00, 8'hFF, 1'b1, 8'h00, 8'hFF, 8'h00},
      {8'hF0, 8'hCC, 1'b0, 8'hF0, 8'hCC, 8'h0C},
      {8'h5A, 8'h3C, 1'b0, 8'h5A, 8'h3C, 8'h24},
      {8'hFF, 8'h96, 1'b0, 8'hFF, 8'h96, 8'h00},
      {8'h0F, 8'hAA, 1'b1, 8'h0F, 8'hAA, 8'h00}
   };

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #100000;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1", "oe in reset", pad_oe, 8'h00);
      chk("R1", "pu in reset", pad_pu, 8'h00);
      rst_n = 1'b1;
      rd(2'd1, r); chk("R1", "dir after reset", r, 8'h00);
      rd(2'd2, r); chk("R1", "latch after reset", r, 8'h00);

      // table walk: R2 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         wr(2'd1, VEC[i][40:33]);
         wr(2'd2, VEC[i][32:25]);
         pullup_off = VEC[i][24];
         #1;
         chk("R2", $sformatf("vec%0d oe", i), pad_oe, VEC[i][23:16]);
         chk("R2", $sformatf("vec%0d out", i), pad_out, VEC[i][15:8]);
         chk("R4/R5", $sformatf("vec%0d pu", i), pad_pu, VEC[i][7:0]);
         chk("R6", $sformatf("vec%0d oe&pu", i), pad_oe & pad_pu, 8'h00);
      end
      pullup_off = 1'b0;

      // R3 toggle, mixed directions
      wr(2'd1, 8'h0F);
      wr(2'd2, 8'h33);
      wr(2'd0, 8'h55);
      chk("R3", "toggled out", pad_out, 8'h66);
      rd(2'd2, r); chk("R3", "toggled latch read", r, 8'h66);
      wr(2'd0, 8'h00);
      chk("R3", "zero mask keeps", pad_out, 8'h66);
      chk("R3", "pu after toggle", pad_pu, 8'h60);

      // R7 readback
      rd(2'd1, r); chk("R7", "dir read", r, 8'h0F);

      // R9 hole address
      wr(2'd3, 8'hFF);
      rd(2'd1, r); chk("R9", "dir after addr3 write", r, 8'h0F);
      rd(2'd2, r); chk("R9", "latch after addr3 write", r, 8'h66);
      rd(2'd3, r); chk("R9", "addr3 read", r, 8'h00);

      // R8 sync timing, R7 pin read with outputs on
      wr(2'd1, 8'hFF);
      @(negedge clk);
      bus_addr = 2'd0;
      pad_in = 8'hA5;
      #1.5;
      chk("R8", "low-phase change before edge", bus_rdata, 8'h00);
      @(posedge clk); #0.5;
      chk("R8", "low-phase change after edge", bus_rdata, 8'hA5);
      pad_in = 8'h3C;
      @(negedge clk); #0.5;
      chk("R8", "high-phase change at fall", bus_rdata, 8'hA5);
      @(posedge clk); #0.5;
      chk("R7", "pin read on outputs", bus_rdata, 8'h3C);

      // R7 pin read with all inputs
      wr(2'd1, 8'h00);
      @(negedge clk); pad_in = 8'hC3;
      repeat (2) @(negedge clk);
      rd(2'd0, r); chk("R7", "pin read on inputs", r, 8'hC3);

      finish_run();
   end
endmodule